// File: doc/BRIEF.md
# Slave PCM Serial Port with Selectable Frame Alignment

This block is the slave side of a mono PCM serial link. An external master drives a frame sync and a bit clock. The port sends one parallel transmit word out MSB-first on a serial output and assembles one receive word from a serial input. A system clock that runs much faster than the bit clock oversamples all three serial pins. All framing decisions are taken from the edge strobes that this oversampling produces.

Three format inputs set where the first transmit bit sits relative to the rising edge of the frame sync:

- a family select (mode 0 / mode 1);
- an early/late MSB select;
- a bit-clock sense select, which picks whether bits are launched on rising or falling bit-clock edges.

Receive bits are always taken on the edge of the other sense. The format is sampled once per word, at the sync rising edge. On that same edge the transmit word is taken from the parallel input. A one-cycle valid pulse hands the finished receive word back.

Top module: `pcm_serial_port`

## Requirements

Terms used below:

- The launch edge is the rising bit-clock edge when `fmt_inv_clk`=0 and the falling edge when it is 1.
- The capture edge is the other sense.
- All edges are counted from the sync rising edge.

Requirements:

- R1: With `fmt_mode`=0, `fmt_late_msb`=0, `fmt_inv_clk`=0, the MSB is driven on the first rising edge that follows the first falling edge.
- R2: With `fmt_mode`=0, `fmt_late_msb`=0, `fmt_inv_clk`=1, the MSB is driven on the first falling edge that follows the first rising edge.
- R3: With `fmt_mode`=0, `fmt_late_msb`=1, the MSB is driven on the second launch edge.
- R4: With `fmt_mode`=1, `fmt_late_msb`=0, the MSB appears on `sdout_pin` right after the sync rising edge, before any bit-clock edge.
- R5: With `fmt_mode`=1, `fmt_late_msb`=1, the MSB is driven on the first launch edge.
- R6: Each bit is captured from `sdin_pin` on the first capture edge after it is driven. The next transmit bit is driven on the launch edge after that capture. A word is `W` bits (default 16), MSB first in both directions.
- R7: `tx_word` is taken at the sync rising edge, and `tx_taken` pulses for exactly one system cycle, once per sync rising edge.
- R8: One system cycle after the last bit is captured, `rx_valid` pulses for one cycle. `rx_word` then holds the received word, and it changes at no other time.
- R9: `sdout_pin` is 0 from the sync rising edge until the MSB is driven (except in the R4 format). It is also 0 from the launch edge that follows the last capture until the next word.
- R10: A sync rising edge during a word abandons that word, with no `rx_valid`, and starts a new one.
- R11: Changes on the format inputs after the sync rising edge have no effect on the word in progress.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| fsync_pin | input | 1 | Frame sync from the master |
| bclk_pin | input | 1 | Bit clock from the master |
| sdin_pin | input | 1 | Serial receive data |
| fmt_mode | input | 1 | Timing family select |
| fmt_late_msb | input | 1 | Early/late MSB select |
| fmt_inv_clk | input | 1 | 0: launch on rising, capture on falling; 1: the reverse |
| tx_word | input | W | Parallel transmit word |
| tx_taken | output | 1 | One-cycle pulse when `tx_word` is taken |
| sdout_pin | output | 1 | Serial transmit data |
| rx_word | output | W | Last complete receive word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |

## Verification

The assertions watch properties that hold on every cycle:

- the single-cycle shape of `rx_valid` and `tx_taken`;
- `rx_word` moving only together with `rx_valid`;
- the held format staying fixed between sync edges;
- the output being low, or already carrying the MSB in the R4 format, on the cycle after a word starts.

Only the bench scenarios can show which bit-clock edge carries the MSB in each of the eight format combinations. The same holds for the bit order and the captured word. They also cover the abandonment of a word by a second sync, and the immunity to format changes in mid-word. Each of these depends on a sequence of pin edges rather than on one cycle.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    // Phase of the framer within one word.
    typedef enum logic [2:0] {
        PH_IDLE,   // no word active, output low
        PH_ARM,    // waiting for a capture-sense edge before counting
        PH_WAIT,   // counting launch edges up to the MSB
        PH_SHIFT,  // bits are being driven and captured
        PH_TAIL    // last bit captured, output holds LSB until next launch
    } phase_e;

    // Frame format, held for a whole word.
    typedef struct packed {
        logic mode;      // timing family
        logic late_msb;  // MSB placed later
        logic inv_clk;   // launch on falling edge when set
    } fmt_t;

    // Launch edges to count before the MSB appears (0 = at sync).
    function automatic logic [1:0] launches_before_msb(fmt_t f);
        if (f.mode) return f.late_msb ? 2'd1 : 2'd0;
        else        return f.late_msb ? 2'd2 : 2'd1;
    endfunction

    // Family 0 with early MSB must first see a capture-sense edge.
    function automatic logic needs_arming(fmt_t f);
        return !f.mode && !f.late_msb;
    endfunction

    function automatic phase_e start_phase(fmt_t f);
        if (launches_before_msb(f) == 2'd0) return PH_SHIFT;
        if (needs_arming(f))                return PH_ARM;
        return PH_WAIT;
    endfunction

endpackage

// File: rtl/pcm_pin_sync.sv
module pcm_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fsync_pin,
    input  logic bclk_pin,
    input  logic sdin_pin,
    output logic fs_rise,
    output logic bk_rise,
    output logic bk_fall,
    output logic sd_level
);
    localparam int NPIN = 3;
    localparam int TOP  = STAGES - 1;

    logic [NPIN-1:0]   pins;
    logic [STAGES-1:0] sync_q [NPIN];
    logic              fs_hist;
    logic              bk_hist;

    assign pins = {sdin_pin, bclk_pin, fsync_pin};

    for (genvar g = 0; g < NPIN; g++) begin : g_chain
        always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= '0;
            else     sync_q[g] <= {sync_q[g][STAGES-2:0], pins[g]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_hist <= 1'b0;
            bk_hist <= 1'b0;
        end else begin
            fs_hist <= sync_q[0][TOP];
            bk_hist <= sync_q[1][TOP];
        end
    end

    assign fs_rise  = sync_q[0][TOP] & ~fs_hist;
    assign bk_rise  = sync_q[1][TOP] & ~bk_hist;
    assign bk_fall  = ~sync_q[1][TOP] & bk_hist;
    assign sd_level = sync_q[2][TOP];

endmodule

// File: rtl/pcm_framer.sv
module pcm_framer
    import pcm_port_pkg::*;
#(
    parameter int W = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fs_rise,
    input  logic bk_rise,
    input  logic bk_fall,
    input  fmt_t fmt_in,
    output fmt_t fmt_q,
    output logic load,
    output logic shift_next,
    output logic capture,
    output logic last_capture,
    output logic drive_en
);
    localparam int IW = (W > 1) ? $clog2(W) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(W - 1);

    phase_e        phase;
    logic [1:0]    launch_cnt;
    logic [IW-1:0] bit_idx;
    logic          took_cap;
    logic          launch_stb;
    logic          cap_stb;

    // Edge roles follow the held clock sense.
    assign launch_stb = fmt_q.inv_clk ? bk_fall : bk_rise;
    assign cap_stb    = fmt_q.inv_clk ? bk_rise : bk_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            fmt_q      <= '0;
            launch_cnt <= '0;
            bit_idx    <= '0;
            took_cap   <= 1'b0;
        end else if (fs_rise) begin
            fmt_q      <= fmt_in;
            phase      <= start_phase(fmt_in);
            launch_cnt <= '0;
            bit_idx    <= '0;
            took_cap   <= 1'b0;
        end else begin
            unique case (phase)
                PH_ARM: begin
                    if (cap_stb) phase <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (launch_stb) begin
                        if (launch_cnt + 2'd1 == launches_before_msb(fmt_q))
                            phase <= PH_SHIFT;
                        launch_cnt <= launch_cnt + 2'd1;
                    end
                end
                PH_SHIFT: begin
                    if (cap_stb && !took_cap) begin
                        took_cap <= 1'b1;
                        if (bit_idx == LAST_IDX) phase <= PH_TAIL;
                    end else if (launch_stb && took_cap) begin
                        took_cap <= 1'b0;
                        bit_idx  <= bit_idx + 1'b1;
                    end
                end
                PH_TAIL: begin
                    if (launch_stb) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign load         = fs_rise;
    assign capture      = !fs_rise && (phase == PH_SHIFT) && cap_stb && !took_cap;
    assign last_capture = capture && (bit_idx == LAST_IDX);
    assign shift_next   = !fs_rise && (phase == PH_SHIFT) && launch_stb && took_cap
                          && !cap_stb;
    assign drive_en     = (phase == PH_SHIFT) || (phase == PH_TAIL);

endmodule

// File: rtl/pcm_shifter.sv
module pcm_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] tx_word,
    input  logic         shift_next,
    input  logic         capture,
    input  logic         last_capture,
    input  logic         sd_level,
    output logic         tx_msb,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    logic [W-1:0] tx_sr;
    logic [W-1:0] rx_sr;
    logic [W-1:0] rx_next;

    assign rx_next = {rx_sr[W-2:0], sd_level};
    assign tx_msb  = tx_sr[W-1];

    always_ff @(posedge clk) begin
        if (rst)             tx_sr <= '0;
        else if (load)       tx_sr <= tx_word;
        else if (shift_next) tx_sr <= {tx_sr[W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_sr    <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (capture) rx_sr <= rx_next;
            if (last_capture) begin
                rx_word  <= rx_next;
                rx_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fsync_pin,
    input  logic         bclk_pin,
    input  logic         sdin_pin,
    input  logic         fmt_mode,
    input  logic         fmt_late_msb,
    input  logic         fmt_inv_clk,
    input  logic [W-1:0] tx_word,
    output logic         tx_taken,
    output logic         sdout_pin,
    output logic [W-1:0] rx_word,
    output logic         rx_valid
);
    logic fs_rise, bk_rise, bk_fall, sd_level;
    logic load, shift_next, capture, last_capture, drive_en, tx_msb;
    fmt_t fmt_in;
    fmt_t fmt_q;

    assign fmt_in = {fmt_mode, fmt_late_msb, fmt_inv_clk};

    pcm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .fsync_pin(fsync_pin),
        .bclk_pin (bclk_pin),
        .sdin_pin (sdin_pin),
        .fs_rise  (fs_rise),
        .bk_rise  (bk_rise),
        .bk_fall  (bk_fall),
        .sd_level (sd_level)
    );

    pcm_framer #(.W(W)) u_framer (
        .clk         (clk),
        .rst         (rst),
        .fs_rise     (fs_rise),
        .bk_rise     (bk_rise),
        .bk_fall     (bk_fall),
        .fmt_in      (fmt_in),
        .fmt_q       (fmt_q),
        .load        (load),
        .shift_next  (shift_next),
        .capture     (capture),
        .last_capture(last_capture),
        .drive_en    (drive_en)
    );

    pcm_shifter #(.W(W)) u_shift (
        .clk         (clk),
        .rst         (rst),
        .load        (load),
        .tx_word     (tx_word),
        .shift_next  (shift_next),
        .capture     (capture),
        .last_capture(last_capture),
        .sd_level    (sd_level),
        .tx_msb      (tx_msb),
        .rx_word     (rx_word),
        .rx_valid    (rx_valid)
    );

    assign tx_taken  = load;
    assign sdout_pin = drive_en & tx_msb;

endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         tx_taken,
    input logic         rx_valid,
    input logic [W-1:0] rx_word,
    input logic         sdout_pin,
    input logic         tx_msb_in,
    input logic         fmt_mode,
    input logic         fmt_late_msb,
    input logic [2:0]   fmt_q
);
    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);                                        // R8

    AST_RXWORD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> (rx_valid || $stable(rx_word)));                  // R8

    AST_TAKEN_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tx_taken |=> !tx_taken);                                        // R7

    AST_FMT_HELD: assert property (@(posedge clk) disable iff (rst)
        !tx_taken |=> $stable(fmt_q));                                  // R11

    AST_START_QUIET: assert property (@(posedge clk) disable iff (rst)
        (tx_taken && !(fmt_mode && !fmt_late_msb)) |=> !sdout_pin);     // R9

    AST_IMMEDIATE_MSB: assert property (@(posedge clk) disable iff (rst)
        (tx_taken && fmt_mode && !fmt_late_msb) |=> (sdout_pin == $past(tx_msb_in))); // R4

endmodule

bind pcm_serial_port pcm_serial_port_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_taken    (tx_taken),
    .rx_valid    (rx_valid),
    .rx_word     (rx_word),
    .sdout_pin   (sdout_pin),
    .tx_msb_in   (tx_word[W-1]),
    .fmt_mode    (fmt_mode),
    .fmt_late_msb(fmt_late_msb),
    .fmt_q       (fmt_q)
);

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
    localparam int W    = 16;
    localparam int HALF = 8;
    localparam int FULL_EDGES = 2 * (W + 3);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         fsync_pin = 1'b0;
    logic         bclk_pin = 1'b0;
    logic         sdin_pin = 1'b0;
    logic         fmt_mode = 1'b0;
    logic         fmt_late_msb = 1'b0;
    logic         fmt_inv_clk = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_taken;
    logic         sdout_pin;
    logic [W-1:0] rx_word;
    logic         rx_valid;

    int n_tests = 0;
    int n_fail  = 0;
    int rxv_cnt = 0;
    int take_cnt = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pcm_serial_port #(.W(W)) u0 (
        .clk(clk), .rst(rst), .fsync_pin(fsync_pin), .bclk_pin(bclk_pin),
        .sdin_pin(sdin_pin), .fmt_mode(fmt_mode), .fmt_late_msb(fmt_late_msb),
        .fmt_inv_clk(fmt_inv_clk), .tx_word(tx_word), .tx_taken(tx_taken),
        .sdout_pin(sdout_pin), .rx_word(rx_word), .rx_valid(rx_valid)
    );

    always @(negedge clk) begin
        if (rx_valid) rxv_cnt++;
        if (tx_taken) take_cnt++;
    end

    // {mode, late_msb, inv_clk, tx[15:0], rx[15:0]}
    localparam logic [34:0] VEC [8] = '{
        {3'b000, 16'hA5C3, 16'h3C5A},
        {3'b001, 16'h8001, 16'hF00F},
        {3'b010, 16'h1234, 16'hFEDC},
        {3'b011, 16'hFFFE, 16'h0001},
        {3'b100, 16'hC0DE, 16'hBEEF},
        {3'b101, 16'h7FFF, 16'h8000},
        {3'b110, 16'h5AA5, 16'h0FF0},
        {3'b111, 16'h9669, 16'h6996}
    };

    function automatic string tag_of(logic m, logic l, logic p);
        if (m)  return l ? "R5" : "R4";
        if (l)  return "R3";
        return p ? "R2" : "R1";
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one frame and compares sdout against an edge-walk model.
    task automatic run_frame(input logic m, input logic l, input logic p,
                             input logic [W-1:0] tx, input logic [W-1:0] rx,
                             input int max_edges, input bit flip_fmt,
                             output int mism);
        int  need;
        bit  armed, started, capd, done, gone, is_launch;
        int  cnt, idx;
        logic exp_out;
        mism = 0;
        need = m ? (l ? 1 : 0) : (l ? 2 : 1);
        armed = !(!m && !l);
        started = 0; capd = 0; done = 0; gone = 0; cnt = 0; idx = 0;
        @(negedge clk);
        fmt_mode = m; fmt_late_msb = l; fmt_inv_clk = p; tx_word = tx;
        repeat (3) @(negedge clk);
        fsync_pin = 1'b1;
        if (need == 0) begin
            started = 1;
            sdin_pin = rx[W-1];
        end
        repeat (HALF) @(negedge clk);
        exp_out = (started && !gone) ? tx[W-1-idx] : 1'b0;
        if (sdout_pin !== exp_out) mism++;
        for (int e = 0; e < max_edges; e++) begin
            if (e == 2) fsync_pin = 1'b0;
            if (flip_fmt && e == 3) begin
                fmt_mode = ~m; fmt_late_msb = ~l; fmt_inv_clk = ~p;
                tx_word = ~tx;
            end
            @(negedge clk);
            bclk_pin = ~bclk_pin;
            is_launch = (bclk_pin != p);
            if (!started) begin
                if (!armed) begin
                    if (!is_launch) armed = 1;
                end else if (is_launch) begin
                    cnt++;
                    if (cnt == need) begin
                        started = 1; idx = 0; capd = 0;
                        sdin_pin = rx[W-1];
                    end
                end
            end else if (!gone) begin
                if (is_launch) begin
                    if (done) gone = 1;
                    else if (capd) begin
                        idx++; capd = 0;
                        sdin_pin = rx[W-1-idx];
                    end
                end else if (!capd && !done) begin
                    capd = 1;
                    if (idx == W - 1) done = 1;
                end
            end
            repeat (HALF - 1) @(negedge clk);
            exp_out = (started && !gone) ? tx[W-1-idx] : 1'b0;
            if (sdout_pin !== exp_out) mism++;
        end
        repeat (4) @(negedge clk);
    endtask

    initial begin
        int mism, rx0, tk0;
        repeat (4) @(negedge clk);
        // reset state
        check(sdout_pin == 1'b0, "R9", "sdout in reset", int'(sdout_pin), 0);
        check(rx_valid == 1'b0 && rx_word == '0, "R8", "rx outputs in reset",
              int'(rx_word), 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // table walk: all eight formats
        for (int i = 0; i < 8; i++) begin
            logic [34:0] v;
            v = VEC[i];
            rx0 = rxv_cnt; tk0 = take_cnt;
            run_frame(v[34], v[33], v[32], v[31:16], v[15:0], FULL_EDGES, 1'b0, mism);
            check(mism == 0, tag_of(v[34], v[33], v[32]), "sdout bit timing mismatches",
                  mism, 0);
            check(rx_word == v[15:0], "R6", "rx_word", int'(rx_word), int'(v[15:0]));
            check(rxv_cnt - rx0 == 1, "R8", "rx_valid pulses", rxv_cnt - rx0, 1);
            check(take_cnt - tk0 == 1, "R7", "tx_taken pulses", take_cnt - tk0, 1);
            check(sdout_pin == 1'b0, "R9", "sdout after word", int'(sdout_pin), 0);
        end

        // restart in mid-word: partial frame then a full frame
        rx0 = rxv_cnt;
        run_frame(1'b0, 1'b1, 1'b0, 16'hDEAD, 16'h1111, 10, 1'b0, mism);
        check(rxv_cnt - rx0 == 0, "R10", "rx_valid from abandoned word", rxv_cnt - rx0, 0);
        run_frame(1'b0, 1'b1, 1'b0, 16'h4321, 16'h2468, FULL_EDGES, 1'b0, mism);
        check(mism == 0, "R10", "sdout after restart", mism, 0);
        check(rx_word == 16'h2468 && rxv_cnt - rx0 == 1, "R10", "rx after restart",
              int'(rx_word), 16'h2468);

        // format and tx_word changes in mid-word are ignored
        run_frame(1'b0, 1'b0, 1'b1, 16'hB00B, 16'h7E57, FULL_EDGES, 1'b1, mism);
        check(mism == 0, "R11", "sdout with mid-word format change", mism, 0);
        check(rx_word == 16'h7E57, "R11", "rx with mid-word format change",
              int'(rx_word), 16'h7E57);
        check(rx_word == 16'h7E57, "R8", "rx_word holds after frame",
              int'(rx_word), 16'h7E57);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule